// File: doc/BRIEF.md
# Two-Wire Bus Control Register Unit

This block is the control and status front end of a two-wire serial interface. Software writes a control byte and a data byte. The serial engine raises an event flag when a transfer step completes. The block decodes these inputs into request and enable lines for the bit-level engine, and it gates that engine's open-drain line drives. It also samples SCL and SDA to detect START and STOP conditions and to keep a bus-busy indication.

A controller state machine sequences bus ownership. Its states are:
- ST_OFF: the interface is disabled.
- ST_IDLE: enabled and not addressed.
- ST_WAIT: a START is requested but another master holds the bus.
- ST_START: a START is being requested from the engine.
- ST_MASTER: the block owns the bus.
- ST_STOP: a STOP is being requested from the engine.
- ST_RELEASE: slave error recovery, with both lines released.

Its transitions are:
- Any state goes to ST_OFF whenever enable is low.
- ST_OFF goes to ST_IDLE once enabled.
- ST_IDLE goes to ST_START on a start request when the bus is free, and to ST_WAIT on a start request when the bus is busy.
- ST_WAIT goes to ST_START on a detected STOP, and back to ST_IDLE if the start request is withdrawn.
- ST_START goes to ST_MASTER on a detected START.
- ST_MASTER goes to ST_STOP on a stop request.
- ST_STOP goes to ST_IDLE on a detected STOP.
- ST_IDLE or ST_WAIT goes to ST_RELEASE on a stop request.
- ST_RELEASE goes to ST_IDLE once the engine drives neither line.

Top module: `twc_unit`

## Requirements
- R1: The control byte reads back as {flag[7], ack_en[6], start[5], stop[4], collide[3], enable[2], 0[1], int_en[0]}. After reset it reads 0x00. A pulse on `flag_set` sets bit 7. Writing a control byte with bit 7 set clears bit 7.
- R2: Bit 1 of the control byte always reads zero, whatever is written to it.
- R3: `eng_ack_en` is high exactly when ack_en and enable are both set. Clearing ack_en stops address acknowledgement.
- R4: A start request with the bus free raises `start_go` within a few cycles. With the bus busy, `start_go` stays low until a STOP is detected, and then it rises.
- R5: The start bit is not cleared by hardware. It still reads 1 after the block's START has appeared on the bus.
- R6: In master mode, a stop request raises `stop_go`. The stop bit clears by itself once a STOP is detected on the bus, and `stop_go` falls at the same point.
- R7: Outside master mode, a stop request never raises `stop_go`. Instead it clears the stop bit, raises `slave_rst`, and forces `scl_oe` and `sda_oe` low until the engine stops driving both lines.
- R8: A data write while the flag is low sets the collide bit and leaves `dat_rdata` unchanged. A data write while the flag is high stores the byte and clears the collide bit.
- R9: With enable low, `eng_en`, `start_go`, `stop_go`, `scl_oe` and `sda_oe` are all low, and any transfer in progress is abandoned.
- R10: `irq` is high while the flag, int_en and `glob_ie` are all set, and low otherwise.
- R11: `bus_busy` rises after SDA falls while SCL is high, falls after SDA rises while SCL is high, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write value |
| reg_rdata | output | 8 | Control byte readback |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | DATA_W | Data write value |
| dat_rdata | output | DATA_W | Data register contents |
| flag_set | input | 1 | Engine event pulse that sets the flag |
| glob_ie | input | 1 | Global interrupt enable |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| eng_scl_low | input | 1 | Engine wants SCL pulled low |
| eng_sda_low | input | 1 | Engine wants SDA pulled low |
| start_go | output | 1 | START request to engine |
| stop_go | output | 1 | STOP request to engine |
| eng_en | output | 1 | Engine enable |
| eng_ack_en | output | 1 | Address acknowledge enable |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | SCL open-drain pull-down enable |
| sda_oe | output | 1 | SDA open-drain pull-down enable |
| slave_rst | output | 1 | Slave error-recovery indication |
| bus_busy | output | 1 | Bus occupied indication |

## Verification
A wrong controller state shows up at the ports within two cycles of the event that caused it. A missed transition from ST_WAIT leaves `start_go` low after the bus STOP. A stuck ST_STOP leaves the stop bit set in the readback. A missed ST_RELEASE leaves `scl_oe` or `sda_oe` high. A bad bus monitor shows on `bus_busy` a few cycles after the line edges, and it also delays or suppresses `start_go`. Register faults are visible on the next read of `reg_rdata` or `dat_rdata`.

// File: rtl/twc_pkg.sv
package twc_pkg;
    localparam int unsigned B_FLAG  = 7;
    localparam int unsigned B_ACK   = 6;
    localparam int unsigned B_START = 5;
    localparam int unsigned B_STOP  = 4;
    localparam int unsigned B_COL   = 3;
    localparam int unsigned B_EN    = 2;
    localparam int unsigned B_IE    = 0;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_WAIT,
        ST_START,
        ST_MASTER,
        ST_STOP,
        ST_RELEASE
    } twc_state_e;
endpackage

// File: rtl/twc_bus_mon.sv
module twc_bus_mon #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_det,
    output logic stop_det,
    output logic busy
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_sync;
    logic [LAST:0] sda_sync;
    logic          sda_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync[0] <= scl_in;
                    sda_sync[0] <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[LAST-1:0], scl_in};
                    sda_sync <= {sda_sync[LAST-1:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_sync[LAST];
    end

    assign start_det = scl_sync[LAST] &  sda_prev & ~sda_sync[LAST];
    assign stop_det  = scl_sync[LAST] & ~sda_prev &  sda_sync[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         busy <= 1'b0;
        else if (start_det) busy <= 1'b1;
        else if (stop_det)  busy <= 1'b0;
    end

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy); // R11
    AST_BUSY_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy); // R11
endmodule

// File: rtl/twc_ctrl_fsm.sv
module twc_ctrl_fsm
    import twc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       bus_busy,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       eng_scl_low,
    input  logic       eng_sda_low,
    output twc_state_e state,
    output logic       start_go,
    output logic       stop_go,
    output logic       stop_clr,
    output logic       lines_on,
    output logic       slave_rst
);
    twc_state_e nxt;

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:     nxt = ST_IDLE;
                ST_IDLE: begin
                    if (stop_req)       nxt = ST_RELEASE;
                    else if (start_req) nxt = bus_busy ? ST_WAIT : ST_START;
                end
                ST_WAIT: begin
                    if (stop_req)        nxt = ST_RELEASE;
                    else if (!start_req) nxt = ST_IDLE;
                    else if (stop_det)   nxt = ST_START;
                end
                ST_START:   if (start_det) nxt = ST_MASTER;
                ST_MASTER:  if (stop_req)  nxt = ST_STOP;
                ST_STOP:    if (stop_det)  nxt = ST_IDLE;
                ST_RELEASE: if (!eng_scl_low && !eng_sda_low) nxt = ST_IDLE;
                default:    nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        start_go  = (state == ST_START);
        stop_go   = (state == ST_STOP);
        stop_clr  = ((state == ST_STOP) && stop_det) || (state == ST_RELEASE);
        lines_on  = (state != ST_OFF) && (state != ST_RELEASE);
        slave_rst = (state == ST_RELEASE);
    end

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && en && start_req && !stop_req && !stop_det) |=> state == ST_WAIT); // R4
    AST_SLAVE_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && en && stop_req) |=> (!stop_go && !lines_on)); // R7
endmodule

// File: rtl/twc_regs.sv
module twc_regs
    import twc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              flag_set,
    input  logic              stop_clr,
    output logic [7:0]        ctrl_byte,
    output logic [DATA_W-1:0] data_q,
    output logic              flag_q,
    output logic              ack_q,
    output logic              start_q,
    output logic              stop_q,
    output logic              en_q,
    output logic              ie_q
);
    logic col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            ack_q   <= 1'b0;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            en_q    <= 1'b0;
            ie_q    <= 1'b0;
        end else begin
            if (flag_set)                     flag_q <= 1'b1;
            else if (reg_wr && reg_wdata[B_FLAG]) flag_q <= 1'b0;
            if (reg_wr) begin
                ack_q   <= reg_wdata[B_ACK];
                start_q <= reg_wdata[B_START];
                stop_q  <= reg_wdata[B_STOP];
                en_q    <= reg_wdata[B_EN];
                ie_q    <= reg_wdata[B_IE];
            end else if (stop_clr) begin
                stop_q  <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= 1'b0;
            data_q <= '0;
        end else if (dat_wr) begin
            if (flag_q) begin
                data_q <= dat_wdata;
                col_q  <= 1'b0;
            end else begin
                col_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        ctrl_byte        = '0;
        ctrl_byte[B_FLAG]  = flag_q;
        ctrl_byte[B_ACK]   = ack_q;
        ctrl_byte[B_START] = start_q;
        ctrl_byte[B_STOP]  = stop_q;
        ctrl_byte[B_COL]   = col_q;
        ctrl_byte[B_EN]    = en_q;
        ctrl_byte[B_IE]    = ie_q;
    end

    AST_COLLIDE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !flag_q) |=> (col_q && $stable(data_q))); // R8
    AST_STOP_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_clr && !reg_wr) |=> !stop_q); // R6
endmodule

// File: rtl/twc_unit.sv
module twc_unit
    import twc_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    output logic [DATA_W-1:0] dat_rdata,
    input  logic              flag_set,
    input  logic              glob_ie,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              eng_scl_low,
    input  logic              eng_sda_low,
    output logic              start_go,
    output logic              stop_go,
    output logic              eng_en,
    output logic              eng_ack_en,
    output logic              irq,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              slave_rst,
    output logic              bus_busy
);
    logic       flag_q, ack_q, start_q, stop_q, en_q, ie_q;
    logic       start_det, stop_det, stop_clr, lines_on;
    twc_state_e state;

    twc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .dat_wr    (dat_wr),
        .dat_wdata (dat_wdata),
        .flag_set  (flag_set),
        .stop_clr  (stop_clr),
        .ctrl_byte (reg_rdata),
        .data_q    (dat_rdata),
        .flag_q    (flag_q),
        .ack_q     (ack_q),
        .start_q   (start_q),
        .stop_q    (stop_q),
        .en_q      (en_q),
        .ie_q      (ie_q)
    );

    twc_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .start_det (start_det),
        .stop_det  (stop_det),
        .busy      (bus_busy)
    );

    twc_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en_q),
        .start_req   (start_q),
        .stop_req    (stop_q),
        .bus_busy    (bus_busy),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .eng_scl_low (eng_scl_low),
        .eng_sda_low (eng_sda_low),
        .state       (state),
        .start_go    (start_go),
        .stop_go     (stop_go),
        .stop_clr    (stop_clr),
        .lines_on    (lines_on),
        .slave_rst   (slave_rst)
    );

    assign eng_en     = en_q;
    assign eng_ack_en = ack_q & en_q;
    assign irq        = flag_q & ie_q & glob_ie;
    assign scl_oe     = lines_on & eng_scl_low;
    assign sda_oe     = lines_on & eng_sda_low;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!start_go && !stop_go && !scl_oe && !sda_oe)); // R9
    AST_MASTER_ONLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_go) |-> $past(state == ST_MASTER)); // R7
endmodule

// File: tb/tb_twc_unit.sv
module tb_twc_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       dat_wr = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic [7:0] dat_rdata;
    logic       flag_set = 1'b0;
    logic       glob_ie = 1'b1;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       eng_scl_low = 1'b0;
    logic       eng_sda_low = 1'b0;
    logic       start_go, stop_go, eng_en, eng_ack_en, irq;
    logic       scl_oe, sda_oe, slave_rst, bus_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } exp_item_t;
    exp_item_t sb[$];

    always #2.5 clk = ~clk;

    twc_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .dat_rdata(dat_rdata), .flag_set(flag_set), .glob_ie(glob_ie),
        .scl_in(scl_in), .sda_in(sda_in), .eng_scl_low(eng_scl_low),
        .eng_sda_low(eng_sda_low), .start_go(start_go), .stop_go(stop_go),
        .eng_en(eng_en), .eng_ack_en(eng_ack_en), .irq(irq), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .slave_rst(slave_rst), .bus_busy(bus_busy)
    );

    // sel 0: control byte, 1: data byte, 2: packed outputs, 3: busy
    function automatic logic [7:0] observe(int sel);
        case (sel)
            0:       return reg_rdata;
            1:       return dat_rdata;
            2:       return {start_go, stop_go, eng_en, eng_ack_en, irq, scl_oe, sda_oe, slave_rst};
            default: return {7'b0, bus_busy};
        endcase
    endfunction

    // monitor: pops expected items and compares away from the clock edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_item_t it;
            logic [7:0] act;
            it  = sb.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_val(int sel, logic [7:0] e, string tag);
        exp_item_t it;
        it.sel = sel; it.exp = e; it.tag = tag;
        sb.push_back(it);
        while (sb.size() > 0) @(posedge clk);
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctrl(logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
        settle(3);
    endtask

    task automatic wr_dat(logic [7:0] v);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
        @(negedge clk); dat_wr = 1'b0;
        settle(2);
    endtask

    task automatic pulse_flag();
        @(negedge clk); flag_set = 1'b1;
        @(negedge clk); flag_set = 1'b0;
        settle(2);
    endtask

    task automatic bus_start();
        sda_in = 1'b1; settle(1); scl_in = 1'b1; settle(4);
        sda_in = 1'b0; settle(4);
        scl_in = 1'b0; settle(4);
    endtask

    task automatic bus_stop();
        sda_in = 1'b0; settle(2);
        scl_in = 1'b1; settle(4);
        sda_in = 1'b1; settle(4);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(2);
        expect_val(0, 8'h00, "R1 reset control byte");
        expect_val(2, 8'h00, "R1 reset outputs");
        expect_val(3, 8'h00, "R11 reset not busy");

        wr_ctrl(8'h47);
        expect_val(0, 8'h45, "R2 reserved bit reads zero");
        expect_val(2, 8'h30, "R3 ack enable and engine enable");

        wr_dat(8'hA5);
        expect_val(0, 8'h4D, "R8 collide set on write with flag low");
        expect_val(1, 8'h00, "R8 data unchanged on collision");

        pulse_flag();
        expect_val(0, 8'hCD, "R1 flag set by engine");
        expect_val(2, 8'h38, "R10 irq with all enables");
        glob_ie = 1'b0; settle(1);
        expect_val(2, 8'h30, "R10 irq masked by global enable");
        glob_ie = 1'b1; settle(1);

        wr_dat(8'h3C);
        expect_val(1, 8'h3C, "R8 data stored with flag high");
        expect_val(0, 8'hC5, "R8 collide cleared");

        wr_ctrl(8'hC5);
        expect_val(0, 8'h45, "R1 write one clears flag");
        expect_val(2, 8'h30, "R10 irq drops with flag");

        wr_ctrl(8'h05);
        expect_val(2, 8'h20, "R3 ack enable cleared");

        bus_start();
        expect_val(3, 8'h01, "R11 busy after START");
        wr_ctrl(8'h25);
        settle(4);
        expect_val(2, 8'h20, "R4 start waits while bus busy");
        bus_stop();
        expect_val(3, 8'h00, "R11 free after STOP");
        expect_val(2, 8'hA0, "R4 start issued after STOP");
        bus_start();
        expect_val(2, 8'h20, "R4 start request drops in master");
        expect_val(0, 8'h25, "R5 start bit held by hardware");

        wr_ctrl(8'h15);
        expect_val(2, 8'h60, "R6 master stop request");
        bus_stop();
        expect_val(0, 8'h05, "R6 stop bit auto-cleared");
        expect_val(2, 8'h20, "R6 stop request dropped");

        eng_scl_low = 1'b1; eng_sda_low = 1'b1; settle(1);
        expect_val(2, 8'h26, "R7 lines driven when idle");
        wr_ctrl(8'h15);
        expect_val(0, 8'h05, "R7 slave stop bit cleared");
        expect_val(2, 8'h21, "R7 slave recovery releases lines");
        eng_scl_low = 1'b0; eng_sda_low = 1'b0; settle(3);
        expect_val(2, 8'h20, "R7 recovery ends when engine idle");
        eng_scl_low = 1'b1; eng_sda_low = 1'b1; settle(1);
        expect_val(2, 8'h26, "R7 lines driven again");

        wr_ctrl(8'h25);
        expect_val(2, 8'hA6, "R4 start issued on free bus");
        wr_ctrl(8'h20);
        expect_val(0, 8'h20, "R9 enable cleared in readback");
        expect_val(2, 8'h00, "R9 disable aborts and releases");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule